// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block runs the coherence logic for one private, direct-mapped, write-back cache attached to a shared snooping bus. Each line holds a tag, a one-word data block and a three-valued coherence state: Invalid, Shared or Modified. Processor reads and writes arrive on a valid/ready request port. Every accepted request gets exactly one response pulse. The response carries the read data, or the value just written.

When a request cannot be served locally, the controller raises a bus request. It presents the transaction it needs: a read, a read-for-ownership, an ownership upgrade, or a writeback of a dirty victim. It waits for a one-cycle grant from the external arbiter. After a read or read-for-ownership it also waits for the fill word. The controller watches transactions that other caches place on the bus. It downgrades or invalidates its own copy when needed. When it holds the only dirty copy, it flushes the data onto the bus.

Snoops take precedence over new processor lookups. The command offered to the arbiter is recomputed every cycle from the current line state. A request that loses its copy to a snoop while it waits for the grant therefore changes to the transaction it now needs.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_req_ready` is high, and `bus_req`, `cpu_resp_valid` and `flush_valid` are low. The first read of any address therefore misses.
- R2: A read of an Invalid line raises `bus_req` with command 1 (read). After the grant and the fill word, the line is Shared and the response returns the fill word. A later read of a Shared or Modified line responds one cycle after acceptance and makes no bus request.
- R3: A write to an Invalid line uses command 2 (read-for-ownership) and leaves the line Modified. Writes and reads to a Modified line complete with no bus request.
- R4: A write to a Shared line uses command 3 (upgrade). It takes no fill word and responds in the cycle after the grant, leaving the line Modified.
- R5: A snooped read (command 1) that hits a Modified line pulses `flush_valid` one cycle later, with the line data on `flush_data`. The line becomes Shared, so the next local write needs an upgrade.
- R6: A snooped read-for-ownership (command 2) that hits a Modified line flushes the data in the same way and leaves the line Invalid.
- R7: A snooped read-for-ownership or upgrade (command 3) that hits a Shared line invalidates it without a flush. A snooped read of a Shared line changes nothing.
- R8: A miss whose line holds a Modified block of another tag first issues command 4 (writeback), with the victim address and data. It then issues the fill command. A Shared victim is dropped with no writeback.
- R9: If a snoop invalidates the line of a pending upgrade before the grant, the controller offers command 2 instead.
- R10: `cpu_req_ready` is low in every cycle in which `snoop_valid` is high.
- R11: `bus_req` stays high until granted, and `bus_cmd_o` is 0 whenever `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle if valid |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_rdata | output | DATA_W | Read data or written value |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | One-cycle grant |
| bus_cmd_o | output | 3 | 0 none, 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_data_o | output | DATA_W | Writeback data |
| bus_fill_valid | input | 1 | Fill word present |
| bus_fill_data | input | DATA_W | Fill word |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 3 | Snooped command, same encoding as `bus_cmd_o` |
| snoop_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | Dirty data supplied to the bus |
| flush_data | output | DATA_W | Flushed word |

## Verification
The bench targets the transitions that a careless design gets wrong in ways that stay invisible to the processor:
- A write to a Shared line must appear on the bus as an upgrade. A design that treats it as a hit would leave stale copies in other caches.
- Snooped reads and read-for-ownership transactions must flush a Modified line, and must leave it Shared or Invalid respectively. An unchanged line would later show up as a missing upgrade or a missing refetch.
- A dirty victim must be written back before the fill. A clean victim must not be.
- A pending upgrade whose line is invalidated while it waits must turn into a read-for-ownership. A design that keeps the stale command would gain ownership without the current data.
- Snoop precedence is checked by sampling the ready output during every snoop.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [2:0] {
    BUS_NONE = 3'd0,
    BUS_RD   = 3'd1,
    BUS_RDX  = 3'd2,
    BUS_UPGR = 3'd3,
    BUS_WB   = 3'd4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_MISS = 2'd1,
    C_FILL = 2'd2
  } ctl_e;

endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup port (processor side)
  input  logic [IDX_W-1:0]  a_idx,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_e          a_st,
  output logic [DATA_W-1:0] a_data,
  // lookup port (snoop side)
  input  logic [IDX_W-1:0]  b_idx,
  output logic [TAG_W-1:0]  b_tag,
  output line_st_e          b_st,
  output logic [DATA_W-1:0] b_data,
  // state write port
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  line_st_e          st_val,
  // tag and data write port
  input  logic              ln_we,
  input  logic [IDX_W-1:0]  ln_idx,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data
);
  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic st_en, ln_en;
    assign st_en = st_we && (st_idx == IDX_W'(g));
    assign ln_en = ln_we && (ln_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q[g] <= LN_I;
      else if (st_en) st_q[g] <= st_val;
    end

    always_ff @(posedge clk) begin
      if (ln_en) begin
        tag_q[g]  <= ln_tag;
        data_q[g] <= ln_data;
      end
    end
  end

  assign a_tag  = tag_q[a_idx];
  assign a_st   = st_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_st   = st_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/msi_bus_pick.sv
module msi_bus_pick
  import msi_pkg::*;
(
  input  logic     want_write,
  input  logic     tag_hit,
  input  line_st_e ln_st,
  output bus_cmd_e cmd
);
  always_comb begin
    if (ln_st == LN_M && !tag_hit)                  cmd = BUS_WB;
    else if (tag_hit && ln_st == LN_S && want_write) cmd = BUS_UPGR;
    else if (want_write)                             cmd = BUS_RDX;
    else                                             cmd = BUS_RD;
  end
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [TAG_W-1:0]  ln_tag,
  input  line_st_e          ln_st,
  input  logic [DATA_W-1:0] ln_data,
  output logic              st_we,
  output line_st_e          st_val,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data
);
  logic     hit;
  logic     flush_d;
  bus_cmd_e cmd;
  logic              flush_q;
  logic [DATA_W-1:0] fdata_q;

  assign cmd = bus_cmd_e'(snp_cmd);
  assign hit = snp_valid && (ln_st != LN_I) && (ln_tag == snp_tag);

  always_comb begin
    st_we   = 1'b0;
    st_val  = ln_st;
    flush_d = 1'b0;
    if (hit) begin
      unique case (cmd)
        BUS_RD: begin
          if (ln_st == LN_M) begin
            st_we   = 1'b1;
            st_val  = LN_S;
            flush_d = 1'b1;
          end
        end
        BUS_RDX: begin
          st_we   = 1'b1;
          st_val  = LN_I;
          flush_d = (ln_st == LN_M);
        end
        BUS_UPGR: begin
          if (ln_st == LN_S) begin
            st_we  = 1'b1;
            st_val = LN_I;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end

  always_ff @(posedge clk) begin
    if (flush_d) fdata_q <= ln_data;
  end

  assign flush_valid = flush_q;
  assign flush_data  = fdata_q;
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snoop_valid,
  input  logic [2:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data
);
  logic rst_n_i;

  msi_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  // pending request
  ctl_e              fsm_q, fsm_d;
  logic              p_write_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [DATA_W-1:0] p_wdata_q;
  logic              pend_ld;

  // response
  logic              resp_q, resp_ld;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // array ports
  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic [TAG_W-1:0]  a_tag, b_tag;
  line_st_e          a_st, b_st;
  logic [DATA_W-1:0] a_data, b_data;
  logic              ln_we;
  logic [DATA_W-1:0] ln_data;
  logic              pst_we;
  line_st_e          pst_val;
  logic              sst_we;
  line_st_e          sst_val;
  logic              st_we;
  logic [IDX_W-1:0]  st_idx;
  line_st_e          st_val;

  logic     tag_hit, hit_ok, accept;
  bus_cmd_e pick_cmd;

  assign look_addr = (fsm_q == C_IDLE) ? cpu_req_addr : p_addr_q;
  assign look_idx  = look_addr[IDX_W-1:0];
  assign look_tag  = look_addr[ADDR_W-1:IDX_W];

  // snoop writes of state win over processor-side writes
  assign st_we  = sst_we | pst_we;
  assign st_idx = sst_we ? snoop_addr[IDX_W-1:0] : look_idx;
  assign st_val = sst_we ? sst_val : pst_val;

  msi_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .a_idx  (look_idx),
    .a_tag  (a_tag),
    .a_st   (a_st),
    .a_data (a_data),
    .b_idx  (snoop_addr[IDX_W-1:0]),
    .b_tag  (b_tag),
    .b_st   (b_st),
    .b_data (b_data),
    .st_we  (st_we),
    .st_idx (st_idx),
    .st_val (st_val),
    .ln_we  (ln_we),
    .ln_idx (look_idx),
    .ln_tag (look_tag),
    .ln_data(ln_data)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .snp_valid  (snoop_valid),
    .snp_cmd    (snoop_cmd),
    .snp_tag    (snoop_addr[ADDR_W-1:IDX_W]),
    .ln_tag     (b_tag),
    .ln_st      (b_st),
    .ln_data    (b_data),
    .st_we      (sst_we),
    .st_val     (sst_val),
    .flush_valid(flush_valid),
    .flush_data (flush_data)
  );

  assign tag_hit = (a_st != LN_I) && (a_tag == look_tag);
  assign hit_ok  = tag_hit && (!cpu_req_write || a_st == LN_M);

  msi_bus_pick u_pick (
    .want_write(p_write_q),
    .tag_hit   (tag_hit),
    .ln_st     (a_st),
    .cmd       (pick_cmd)
  );

  assign cpu_req_ready = (fsm_q == C_IDLE) && !snoop_valid;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign bus_req       = (fsm_q == C_MISS);
  assign bus_cmd_o     = bus_req ? pick_cmd : BUS_NONE;
  assign bus_addr_o    = (bus_req && pick_cmd == BUS_WB) ? {a_tag, look_idx} : p_addr_q;
  assign bus_data_o    = a_data;

  // next-state logic
  always_comb begin
    fsm_d   = fsm_q;
    pend_ld = 1'b0;
    ln_we   = 1'b0;
    ln_data = cpu_req_wdata;
    pst_we  = 1'b0;
    pst_val = a_st;
    resp_ld = 1'b0;
    rdata_d = a_data;
    unique case (fsm_q)
      C_IDLE: begin
        if (accept) begin
          if (hit_ok) begin
            resp_ld = 1'b1;
            if (cpu_req_write) begin
              ln_we   = 1'b1;
              ln_data = cpu_req_wdata;
              rdata_d = cpu_req_wdata;
            end
          end else begin
            pend_ld = 1'b1;
            fsm_d   = C_MISS;
          end
        end
      end
      C_MISS: begin
        if (bus_gnt) begin
          unique case (pick_cmd)
            BUS_WB: begin
              pst_we  = 1'b1;
              pst_val = LN_I;
            end
            BUS_UPGR: begin
              pst_we  = 1'b1;
              pst_val = LN_M;
              ln_we   = 1'b1;
              ln_data = p_wdata_q;
              resp_ld = 1'b1;
              rdata_d = p_wdata_q;
              fsm_d   = C_IDLE;
            end
            default: fsm_d = C_FILL;
          endcase
        end
      end
      C_FILL: begin
        if (bus_fill_valid) begin
          pst_we  = 1'b1;
          pst_val = p_write_q ? LN_M : LN_S;
          ln_we   = 1'b1;
          ln_data = p_write_q ? p_wdata_q : bus_fill_data;
          resp_ld = 1'b1;
          rdata_d = ln_data;
          fsm_d   = C_IDLE;
        end
      end
      default: fsm_d = C_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      fsm_q  <= C_IDLE;
      resp_q <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      resp_q <= resp_ld;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_ld) begin
      p_write_q <= cpu_req_write;
      p_addr_q  <= cpu_req_addr;
      p_wdata_q <= cpu_req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (resp_ld) rdata_q <= rdata_d;
  end

  assign cpu_resp_valid = resp_q;
  assign cpu_resp_rdata = rdata_q;
endmodule

// File: rtl/msi_cache_ctrl_chk.sv
module msi_cache_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_resp_valid,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [2:0]        bus_cmd_o,
  input logic              snoop_valid,
  input logic              flush_valid
);
  assert_snoop_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |-> !cpu_req_ready);

  assert_cmd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> bus_cmd_o == 3'd0);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  assert_hit_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> (cpu_resp_valid || !cpu_req_ready));

  assert_upgr_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_req && bus_cmd_o == 3'd3) |=> cpu_resp_valid);

  assert_fill_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && (bus_cmd_o == 3'd1 || bus_cmd_o == 3'd2)) |=> (!bus_req && !cpu_resp_valid));

  assert_wb_then_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_cmd_o == 3'd4) |=> bus_req);

  assert_flush_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(snoop_valid));
endmodule

bind msi_cache_ctrl msi_cache_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_resp_valid(cpu_resp_valid),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_cmd_o     (bus_cmd_o),
  .snoop_valid   (snoop_valid),
  .flush_valid   (flush_valid)
);

// File: tb/msi_cache_ctrl_tb.sv
module msi_cache_ctrl_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [2:0] K_RD = 3'd1, K_RDX = 3'd2, K_UPGR = 3'd3, K_WB = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_resp_valid;
  logic [DW-1:0] cpu_resp_rdata;
  logic bus_req, bus_gnt = 1'b0;
  logic [2:0] bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_data_o;
  logic bus_fill_valid = 1'b0;
  logic [DW-1:0] bus_fill_data = '0;
  logic snoop_valid = 1'b0;
  logic [2:0] snoop_cmd = '0;
  logic [AW-1:0] snoop_addr = '0;
  logic flush_valid;
  logic [DW-1:0] flush_data;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [2:0]    log_cmd[$];
  logic [AW-1:0] log_addr[$];
  logic [DW-1:0] mem[logic [AW-1:0]];
  int            flush_cnt = 0;
  logic [DW-1:0] flush_last = '0;
  logic [AW-1:0] last_snoop = '0;
  bit            hold_gnt = 1'b0;
  int            fill_cnt = 0;
  logic [AW-1:0] fill_addr = '0;

  always #4 clk = ~clk;

  msi_cache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_rdata(cpu_resp_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
    .bus_fill_valid(bus_fill_valid), .bus_fill_data(bus_fill_data),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .flush_valid(flush_valid), .flush_data(flush_data)
  );

  function automatic logic [DW-1:0] memv(logic [AW-1:0] a);
    if (mem.exists(a)) return mem[a];
    return {16'hC0DE, a};
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural memory, arbiter and flush capture
  always @(negedge clk) begin
    bus_gnt = 1'b0;
    bus_fill_valid = 1'b0;
    if (flush_valid) begin
      flush_cnt++;
      flush_last = flush_data;
      mem[last_snoop] = flush_data;
    end
    if (fill_cnt > 0) begin
      fill_cnt--;
      if (fill_cnt == 0) begin
        bus_fill_valid = 1'b1;
        bus_fill_data  = memv(fill_addr);
      end
    end else if (bus_req && !hold_gnt && !snoop_valid) begin
      bus_gnt = 1'b1;
      log_cmd.push_back(bus_cmd_o);
      log_addr.push_back(bus_addr_o);
      if (bus_cmd_o == K_WB) mem[bus_addr_o] = bus_data_o;
      if (bus_cmd_o == K_RD || bus_cmd_o == K_RDX) begin
        fill_cnt  = 2;
        fill_addr = bus_addr_o;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cpu_resp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "unexpected response", cpu_resp_rdata, '0);
      else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cpu_resp_rdata == e, t, cpu_resp_rdata, e);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic cpu_issue(bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] e, string t);
    bit acc = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = d;
    while (!acc) begin
      @(negedge clk);
      acc = cpu_req_ready;
      @(posedge clk); #1;
    end
    cpu_req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while ((exp_q.size() != 0 || bus_req || fill_cnt != 0) && n < 200) begin
      @(posedge clk); n++;
    end
    if (n >= 200) chk(1'b0, "completion", 32'(n), 32'd0);
    repeat (2) @(posedge clk);
  endtask

  task automatic cpu_op(bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] e, string t);
    cpu_issue(w, a, d, e, t);
    wait_done();
  endtask

  task automatic snoop(logic [2:0] c, logic [AW-1:0] a);
    @(posedge clk); #1;
    snoop_valid = 1'b1; snoop_cmd = c; snoop_addr = a; last_snoop = a;
    @(negedge clk);
    chk(cpu_req_ready == 1'b0, "R10 ready low during snoop", 32'(cpu_req_ready), 32'd0);
    @(posedge clk); #1;
    snoop_valid = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic clear_logs();
    log_cmd.delete();
    log_addr.delete();
    flush_cnt = 0;
  endtask

  task automatic chk_log1(logic [2:0] c, logic [AW-1:0] a, string t);
    chk(log_cmd.size() == 1, {t, " bus count"}, 32'(log_cmd.size()), 32'd1);
    if (log_cmd.size() >= 1) begin
      chk(log_cmd[0] == c, {t, " bus cmd"}, 32'(log_cmd[0]), 32'(c));
      chk(log_addr[0] == a, {t, " bus addr"}, 32'(log_addr[0]), 32'(a));
    end
  endtask

  localparam logic [AW-1:0] A = 16'h0010, B = 16'h0021, C = 16'h0018, E = 16'h0028;

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cpu_req_ready == 1'b1, "R1 ready", 32'(cpu_req_ready), 32'd1);
    chk(bus_req == 1'b0, "R1 bus_req", 32'(bus_req), 32'd0);
    chk(bus_cmd_o == 3'd0, "R11 idle cmd", 32'(bus_cmd_o), 32'd0);
    chk(cpu_resp_valid == 1'b0 && flush_valid == 1'b0, "R1 outputs quiet",
        32'({cpu_resp_valid, flush_valid}), 32'd0);

    // R1/R2 read miss then hit
    clear_logs();
    cpu_op(1'b0, A, '0, memv(A), "R2 read miss data");
    chk_log1(K_RD, A, "R1 R2 first read");
    clear_logs();
    cpu_op(1'b0, A, '0, memv(A), "R2 read hit data");
    chk(log_cmd.size() == 0, "R2 hit no bus", 32'(log_cmd.size()), 32'd0);

    // R4 write to Shared, R3 write hit in Modified
    clear_logs();
    cpu_op(1'b1, A, 32'h1111_0001, 32'h1111_0001, "R4 upgrade ack");
    chk_log1(K_UPGR, A, "R4 upgrade");
    clear_logs();
    cpu_op(1'b1, A, 32'h2222_0002, 32'h2222_0002, "R3 write hit ack");
    cpu_op(1'b0, A, '0, 32'h2222_0002, "R3 read after write");
    chk(log_cmd.size() == 0, "R3 modified no bus", 32'(log_cmd.size()), 32'd0);

    // R3 write to Invalid
    clear_logs();
    cpu_op(1'b1, B, 32'h3333_0003, 32'h3333_0003, "R3 write miss ack");
    chk_log1(K_RDX, B, "R3 write miss");

    // R5 snooped read on Modified
    clear_logs();
    snoop(K_RD, B);
    chk(flush_cnt == 1, "R5 flush count", 32'(flush_cnt), 32'd1);
    chk(flush_last == 32'h3333_0003, "R5 flush data", flush_last, 32'h3333_0003);
    clear_logs();
    cpu_op(1'b1, B, 32'h4444_0004, 32'h4444_0004, "R5 write after downgrade");
    chk_log1(K_UPGR, B, "R5 now shared");

    // R6 snooped read-for-ownership on Modified
    clear_logs();
    snoop(K_RDX, A);
    chk(flush_cnt == 1, "R6 flush count", 32'(flush_cnt), 32'd1);
    chk(flush_last == 32'h2222_0002, "R6 flush data", flush_last, 32'h2222_0002);
    clear_logs();
    cpu_op(1'b0, A, '0, 32'h2222_0002, "R6 refetch data");
    chk_log1(K_RD, A, "R6 now invalid");

    // R7 snoops on Shared
    clear_logs();
    snoop(K_RD, A);
    chk(flush_cnt == 0, "R7 read snoop no flush", 32'(flush_cnt), 32'd0);
    cpu_op(1'b0, A, '0, 32'h2222_0002, "R7 still shared data");
    chk(log_cmd.size() == 0, "R7 still shared", 32'(log_cmd.size()), 32'd0);
    clear_logs();
    snoop(K_UPGR, A);
    chk(flush_cnt == 0, "R7 upgrade snoop no flush", 32'(flush_cnt), 32'd0);
    cpu_op(1'b0, A, '0, 32'h2222_0002, "R7 refetch data");
    chk_log1(K_RD, A, "R7 invalidated");

    // R8 replacement: clean victim dropped, dirty victim written back
    clear_logs();
    cpu_op(1'b0, C, '0, memv(C), "R8 clean replace data");
    chk_log1(K_RD, C, "R8 clean victim silent");
    cpu_op(1'b1, C, 32'h5555_0005, 32'h5555_0005, "R8 make dirty");
    clear_logs();
    cpu_op(1'b0, E, '0, memv(E), "R8 dirty replace data");
    chk(log_cmd.size() == 2, "R8 two transactions", 32'(log_cmd.size()), 32'd2);
    if (log_cmd.size() == 2) begin
      chk(log_cmd[0] == K_WB && log_addr[0] == C, "R8 writeback first",
          {13'd0, log_cmd[0], log_addr[0]}, {13'd0, K_WB, C});
      chk(log_cmd[1] == K_RD && log_addr[1] == E, "R8 fill second",
          {13'd0, log_cmd[1], log_addr[1]}, {13'd0, K_RD, E});
    end
    chk(memv(C) == 32'h5555_0005, "R8 writeback data", memv(C), 32'h5555_0005);

    // R9 pending upgrade invalidated before the grant
    clear_logs();
    hold_gnt = 1'b1;
    cpu_issue(1'b1, E, 32'h6666_0006, 32'h6666_0006, "R9 ack");
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(bus_req == 1'b1 && bus_cmd_o == K_UPGR, "R9 offers upgrade",
        32'({bus_req, bus_cmd_o}), 32'({1'b1, K_UPGR}));
    snoop(K_RDX, E);
    @(negedge clk);
    chk(bus_req == 1'b1, "R11 request held", 32'(bus_req), 32'd1);
    chk(bus_cmd_o == K_RDX, "R9 switched to read-for-ownership", 32'(bus_cmd_o), 32'(K_RDX));
    chk(flush_cnt == 0, "R7 shared invalidate no flush", 32'(flush_cnt), 32'd0);
    @(posedge clk); #1;
    hold_gnt = 1'b0;
    wait_done();
    chk_log1(K_RDX, E, "R9 issued");
    clear_logs();
    cpu_op(1'b0, E, '0, 32'h6666_0006, "R9 modified after");
    chk(log_cmd.size() == 0, "R9 modified hit", 32'(log_cmd.size()), 32'd0);

    finish_run();
  end
endmodule